// File: doc/BRIEF.md
# Circular Word Stack Pointer Controller

This block holds the pointer of a hardware stack kept in on-chip RAM. It also holds two limit registers that software programs. It accepts one push or one pop request per cycle. For each access it drives the RAM word address together with a write strobe or a read strobe. The stack grows toward lower addresses and every access is one 16-bit word.

A 3-bit size code selects the stack window. Five codes give circular windows of 32 to 512 words. In these windows the pointer bits inside the window wrap around, so the stack occupies an aligned block that holds the pointer. With the default pointer that block ends at 0xFBFE. One code gives a 1024-word linear window with no wrap. The two remaining codes are refused. A push that leaves the pointer below the lower limit sets a sticky overflow flag. A pop that leaves it above the upper limit sets a sticky underflow flag.

Software reaches the pointer, the two limits, the size code and the flag clears through a small register write port.

Top module: `sysstack_ctrl`

## Requirements
- R1: After reset the pointer is 0xFBFE, the size code is 000, the lower limit is 0xFA00, the upper limit is 0xFBFE, all three flags are 0 and no strobe is active.
- R2: A push alone is taken in the cycle it is requested. In that cycle mem_we is 1, mem_addr is the pointer minus 2 (after wrap) and mem_wdata equals push_data. The pointer then takes that address.
- R3: A pop alone asserts mem_re with mem_addr equal to the current pointer. The pointer then moves up by 2 (after wrap).
- R4: When push and pop are requested together, or neither is requested, there is no strobe and the pointer is unchanged.
- R5: Size codes 000, 001, 010, 011 and 100 select circular windows of 256, 128, 64, 32 and 512 words. Only the pointer bits inside the window change. With a pointer in the block 0xFA00–0xFBFE at size 000, a push from 0xFA00 gives 0xFBFE and a pop from 0xFBFE gives 0xFA00. At size 100 a push from 0xF800 gives 0xFBFE.
- R6: Size code 111 is a 1024-word linear window with no wrap. A push from 0xF600 gives 0xF5FE and a pop from 0xFDFE gives 0xFE00.
- R7: Writing size code 101 or 110 leaves the size unchanged and sets cfg_err_o.
- R8: A push whose new pointer is below the lower limit sets ovf_o. The flag stays set until software clears it.
- R9: A pop whose new pointer is above the upper limit sets unf_o. The flag stays set until software clears it.
- R10: The write port decodes cfg_addr as follows: 0 pointer, 1 lower limit, 2 upper limit, 3 size code in bits [2:0], 4 write-one-to-clear with bit 0 for ovf_o, bit 1 for unf_o and bit 2 for cfg_err_o. In a cycle with cfg_we set, push and pop are ignored: no strobe is driven and the written value is the one that takes effect.
- R11: The pointer is always even, and bit 0 of a pointer write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| push_req | input | 1 | Push request |
| pop_req | input | 1 | Pop request |
| push_data | input | DW | Word to store on a push |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | AW | Register write data |
| mem_addr | output | AW | RAM byte address of the access |
| mem_we | output | 1 | RAM write strobe (push) |
| mem_re | output | 1 | RAM read strobe (pop) |
| mem_wdata | output | DW | RAM write data |
| sp_o | output | AW | Current pointer |
| size_o | output | 3 | Active size code |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| cfg_err_o | output | 1 | Sticky refused-size-code flag |

## Verification
The assertions check on every cycle that the pointer stays even and that the refused codes never become the active size. They also check that simultaneous requests and register writes suppress both strobes, that a push hands its address to the pointer, that a pop reads at the current pointer, that an idle cycle holds the pointer, and that a set overflow flag survives until it is cleared. Only the bench scenarios can show where the wrap points fall for each size code, that code 111 runs linearly past its ends, the exact limit comparisons that set or do not set each flag, and the reset values.

// File: rtl/sysstack_ctrl.sv
module sysstack_ctrl #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] RST_SP  = 16'hFBFE,
  parameter logic [AW-1:0] RST_OVL = 16'hFA00,
  parameter logic [AW-1:0] RST_UNL = 16'hFBFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] push_data,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] sp_o,
  output logic [2:0]    size_o,
  output logic          ovf_o,
  output logic          unf_o,
  output logic          cfg_err_o
);
  localparam logic [2:0] A_SP = 3'd0, A_OVL = 3'd1, A_UNL = 3'd2, A_SIZE = 3'd3, A_CLR = 3'd4;
  localparam logic [AW-1:0] STEP = AW'(2);

  logic [AW-1:0] sp, ovl, unl, mask, sp_dn, sp_up, push_nxt, pop_nxt;
  logic [2:0]    size;
  logic          ovf, unf, cerr, go_push, go_pop;

  always_comb begin
    case (size)
      3'b000:  mask = AW'(16'h01FF);
      3'b001:  mask = AW'(16'h00FF);
      3'b010:  mask = AW'(16'h007F);
      3'b011:  mask = AW'(16'h003F);
      3'b100:  mask = AW'(16'h03FF);
      default: mask = '1;
    endcase
  end

  assign sp_dn    = sp - STEP;
  assign sp_up    = sp + STEP;
  assign push_nxt = (sp & ~mask) | (sp_dn & mask);
  assign pop_nxt  = (sp & ~mask) | (sp_up & mask);

  assign go_push = push_req & ~pop_req & ~cfg_we;
  assign go_pop  = pop_req & ~push_req & ~cfg_we;

  assign mem_we    = go_push;
  assign mem_re    = go_pop;
  assign mem_addr  = go_push ? push_nxt : sp;
  assign mem_wdata = push_data;

  assign sp_o      = sp;
  assign size_o    = size;
  assign ovf_o     = ovf;
  assign unf_o     = unf;
  assign cfg_err_o = cerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp   <= RST_SP;
      ovl  <= RST_OVL;
      unl  <= RST_UNL;
      size <= 3'b000;
      ovf  <= 1'b0;
      unf  <= 1'b0;
      cerr <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_SP:   sp  <= {cfg_wdata[AW-1:1], 1'b0};
        A_OVL:  ovl <= cfg_wdata;
        A_UNL:  unl <= cfg_wdata;
        A_SIZE: begin
          if (cfg_wdata[2:0] == 3'b101 || cfg_wdata[2:0] == 3'b110) cerr <= 1'b1;
          else size <= cfg_wdata[2:0];
        end
        A_CLR: begin
          if (cfg_wdata[0]) ovf  <= 1'b0;
          if (cfg_wdata[1]) unf  <= 1'b0;
          if (cfg_wdata[2]) cerr <= 1'b0;
        end
        default: ;
      endcase
    end else if (go_push) begin
      sp <= push_nxt;
      if (push_nxt < ovl) ovf <= 1'b1;
    end else if (go_pop) begin
      sp <= pop_nxt;
      if (pop_nxt > unl) unf <= 1'b1;
    end
  end
endmodule

module sysstack_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic          pop_req,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic [AW-1:0] cfg_wdata,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          mem_re,
  input logic [AW-1:0] sp_o,
  input logic [2:0]    size_o,
  input logic          ovf_o
);
  // R11
  sp_even_chk: assert property (@(posedge clk) disable iff (!rst_n) sp_o[0] == 1'b0);
  // R4
  both_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |-> (!mem_we && !mem_re));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !mem_we && !mem_re) |=> $stable(sp_o));
  // R10
  cfg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (!mem_we && !mem_re));
  // R2
  push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp_o == $past(mem_addr)));
  // R3
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (mem_addr == sp_o));
  // R7
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (size_o != 3'b101) && (size_o != 3'b110));
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !(cfg_we && cfg_addr == 3'd4 && cfg_wdata[0])) |=> ovf_o);
endmodule

bind sysstack_ctrl sysstack_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
  .sp_o(sp_o), .size_o(size_o), .ovf_o(ovf_o)
);

// File: tb/sysstack_ctrl_test.sv
`timescale 1ns/1ps
module sysstack_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic push_req = 0, pop_req = 0, cfg_we = 0;
  logic [15:0] push_data = '0, cfg_wdata = '0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] mem_addr, mem_wdata, sp_o;
  logic mem_we, mem_re, ovf_o, unf_o, cfg_err_o;
  logic [2:0] size_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] c_addr, c_wdata;
  logic c_we, c_re;

  always #2.5 clk = ~clk;

  sysstack_ctrl uut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req), .push_data(push_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .sp_o(sp_o), .size_o(size_o), .ovf_o(ovf_o), .unf_o(unf_o), .cfg_err_o(cfg_err_o)
  );

  // {push, pop, expected pointer}; size 011, start pointer 0xFBC2
  localparam logic [17:0] VEC [8] = '{
    {2'b10, 16'hFBC0}, {2'b10, 16'hFBFE}, {2'b01, 16'hFBC0}, {2'b01, 16'hFBC2},
    {2'b11, 16'hFBC2}, {2'b01, 16'hFBC4}, {2'b00, 16'hFBC4}, {2'b10, 16'hFBC2}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic step(input logic pu, input logic po, input logic [15:0] d);
    @(negedge clk);
    push_req = pu; pop_req = po; push_data = d;
    #1;
    c_addr = mem_addr; c_we = mem_we; c_re = mem_re; c_wdata = mem_wdata;
    @(posedge clk); #1;
    push_req = 0; pop_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1 sp", sp_o, 16'hFBFE);
    chk("R1 size", size_o, 3'b000);
    chk("R1 flags", {ovf_o, unf_o, cfg_err_o}, 3'b000);
    chk("R1 strobes", {mem_we, mem_re}, 2'b00);

    wr(3'd3, 16'h0003); wr(3'd1, 16'h0000); wr(3'd2, 16'hFFFE); wr(3'd0, 16'hFBC2);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] prev;
      prev = sp_o;
      step(VEC[i][17], VEC[i][16], 16'hA500 + 16'(i));
      chk("R5 table sp", sp_o, VEC[i][15:0]);
      case (VEC[i][17:16])
        2'b10: begin
          chk("R2 table we", {c_we, c_re}, 2'b10);
          chk("R2 table addr", c_addr, VEC[i][15:0]);
          chk("R2 table data", c_wdata, 16'hA500 + 16'(i));
        end
        2'b01: begin
          chk("R3 table re", {c_we, c_re}, 2'b01);
          chk("R3 table addr", c_addr, prev);
        end
        default: chk("R4 table no strobe", {c_we, c_re}, 2'b00);
      endcase
    end

    wr(3'd3, 16'h0000); wr(3'd0, 16'hFA00);
    step(1, 0, 16'h1234);
    chk("R5 256 push wrap addr", c_addr, 16'hFBFE);
    chk("R5 256 push wrap sp", sp_o, 16'hFBFE);
    step(0, 1, 16'h0);
    chk("R5 256 pop wrap addr", c_addr, 16'hFBFE);
    chk("R5 256 pop wrap sp", sp_o, 16'hFA00);

    wr(3'd3, 16'h0004); wr(3'd0, 16'hF800);
    chk("R5 size 512", size_o, 3'b100);
    step(1, 0, 16'h0);
    chk("R5 512 push wrap", sp_o, 16'hFBFE);

    wr(3'd3, 16'h0007); wr(3'd0, 16'hF600);
    step(1, 0, 16'h0);
    chk("R6 linear push", sp_o, 16'hF5FE);
    wr(3'd0, 16'hFDFE);
    step(0, 1, 16'h0);
    chk("R6 linear pop", sp_o, 16'hFE00);

    wr(3'd3, 16'h0005);
    chk("R7 code 101 size kept", size_o, 3'b111);
    chk("R7 code 101 err", cfg_err_o, 1'b1);
    wr(3'd4, 16'h0004);
    chk("R10 clear err", cfg_err_o, 1'b0);
    wr(3'd3, 16'h0006);
    chk("R7 code 110 size kept", size_o, 3'b111);
    chk("R7 code 110 err", cfg_err_o, 1'b1);
    wr(3'd4, 16'h0004);

    wr(3'd3, 16'h0000); wr(3'd1, 16'hFA10); wr(3'd0, 16'hFA12);
    step(1, 0, 16'h0);
    chk("R8 at limit no ovf", ovf_o, 1'b0);
    step(1, 0, 16'h0);
    chk("R8 below limit ovf", ovf_o, 1'b1);
    step(0, 1, 16'h0);
    chk("R8 ovf sticky", ovf_o, 1'b1);
    wr(3'd4, 16'h0001);
    chk("R10 clear ovf", ovf_o, 1'b0);

    wr(3'd2, 16'hFBF0); wr(3'd0, 16'hFBEE);
    step(0, 1, 16'h0);
    chk("R9 at limit no unf", unf_o, 1'b0);
    step(0, 1, 16'h0);
    chk("R9 above limit unf", unf_o, 1'b1);
    step(1, 0, 16'h0);
    chk("R9 unf sticky", unf_o, 1'b1);
    wr(3'd4, 16'h0002);
    chk("R10 clear unf", unf_o, 1'b0);

    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = 16'hFB00; push_req = 1;
    #1;
    chk("R10 write blocks strobe", {mem_we, mem_re}, 2'b00);
    @(posedge clk); #1;
    cfg_we = 0; push_req = 0;
    chk("R10 write wins", sp_o, 16'hFB00);

    wr(3'd0, 16'hFB01);
    chk("R11 odd write", sp_o, 16'hFB00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule